// File: doc/BRIEF.md
# Software Write-Protection Sequence Detector

This block sits between the latched write port of a paged nonvolatile memory and its page write engine. It watches each latched write, an address and data pair, for command patterns. A three-write key pattern arms protection, or opens one page burst while protection is already on. A six-write pattern that starts with the same key drops protection. For every write it gives the page engine a timer-start pulse, `wr_kick`, and a qualifier, `wr_commit`, that says whether the byte may reach the array. While protection is on, a write without the key still starts a full timed cycle but never changes stored data.

The protection flag stands for a nonvolatile bit. It starts at 0 at power-up and the reset input does not clear it. The flag changes only when the page engine reports the end of a write period with `cycle_done`. Any data bytes that follow a command pattern, up to a full page, are written in the same burst. Only the low 15 address bits are compared with the command addresses.

The state machine has eight states. `S_IDLE` waits. `S_KEY1` follows AA written to 5555. `S_KEY2` follows 55 written to 2AAA. From `S_KEY2`, A0 written to 5555 leads to `S_OPEN` (arm or unlock). From `S_KEY2`, 80 written to 5555 leads to `S_ERA1`. From `S_ERA1`, AA to 5555 leads to `S_ERA2`. From `S_ERA2`, 55 to 2AAA leads to `S_ERA3`. From `S_ERA3`, 20 to 5555 leads to `S_CLEAR`. A mismatching write in any of the key or erase states goes back to `S_IDLE`. `cycle_done` moves every state to `S_IDLE`: from `S_OPEN` it sets the flag, and from `S_CLEAR` it clears it.

Top module: `wp_seq_guard`

## Requirements
- R1: After power-up `protect_active` is 0 and `wr_kick`, `wr_commit` and `protect_toggle` are 0 under reset. Reset returns the detector to `S_IDLE` but leaves `protect_active` unchanged.
- R2: Each cycle with `wr_valid` high gives exactly one `wr_kick` pulse in the next cycle. A cycle without `wr_valid` gives none.
- R3: With protection off, a write that is not part of a command pattern gives `wr_commit` = 1, in the same cycle as its `wr_kick`.
- R4: With protection on, a write outside an opened burst gives `wr_kick` = 1 and `wr_commit` = 0, and `protect_active` does not change.
- R5: The key pattern (data AA to address 5555, 55 to 2AAA, A0 to 5555; all hex) is never committed. Writes after it are committed until `cycle_done`, and then `protect_active` becomes 1.
- R6: The erase pattern (AA to 5555, 55 to 2AAA, 80 to 5555, AA to 5555, 55 to 2AAA, 20 to 5555) is never committed. Writes after it are committed, and at `cycle_done` `protect_active` becomes 0.
- R7: Both patterns take effect at `cycle_done` even when no data byte follows them.
- R8: A write that does not match the next expected command byte returns the detector to `S_IDLE` and is judged as a normal write (R3/R4).
- R9: Only address bits 14:0 are compared with the command addresses. Bits above them are ignored.
- R10: A `cycle_done` that arrives partway through a pattern abandons the pattern, so the writes that follow are judged as normal writes.
- R11: `protect_toggle` is a one-cycle pulse in the first cycle in which `protect_active` has its new value, and it occurs only then.
- R12: A key pattern completed while protection is already on leaves `protect_active` at 1 and gives no `protect_toggle`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; does not touch the protection flag |
| wr_valid | input | 1 | One-cycle strobe for a latched write |
| wr_addr | input | ADDR_W (17) | Latched write address |
| wr_data | input | DATA_W (8) | Latched write data |
| cycle_done | input | 1 | One-cycle pulse from the page engine when a write period ends |
| wr_kick | output | 1 | Registered pulse that starts the write timer for every write |
| wr_commit | output | 1 | Registered qualifier: the byte of this write may be stored |
| protect_active | output | 1 | Current software protection state |
| protect_toggle | output | 1 | One-cycle pulse when protection changes |

## Verification
The bench drives clean key, unlock and erase patterns, each with and without trailing data bytes. This separates the arming of the flag from the committing of the data. Patterns broken at different depths show whether the byte that breaks a pattern is judged as a normal write. Command addresses with high bits set show that those bits are ignored. A `cycle_done` or a reset dropped into a half-finished pattern shows that the detector returns to idle while the protection flag keeps its value.

// File: rtl/wpg_pkg.sv
package wpg_pkg;

    localparam int CMD_AW  = 15;
    localparam int CODE_W  = 8;
    localparam int N_CODES = 5;

    localparam int C_KEY_AA = 0;
    localparam int C_KEY_55 = 1;
    localparam int C_OPEN   = 2;
    localparam int C_ERA80  = 3;
    localparam int C_CLR20  = 4;

    typedef struct packed {
        logic [CMD_AW-1:0] addr;
        logic [CODE_W-1:0] data;
    } cmd_code_t;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_KEY1  = 3'd1,
        S_KEY2  = 3'd2,
        S_OPEN  = 3'd3,
        S_ERA1  = 3'd4,
        S_ERA2  = 3'd5,
        S_ERA3  = 3'd6,
        S_CLEAR = 3'd7
    } seq_state_t;

    function automatic cmd_code_t code_at(input int idx);
        cmd_code_t c;
        case (idx)
            C_KEY_AA: c = '{addr: 15'h5555, data: 8'hAA};
            C_KEY_55: c = '{addr: 15'h2AAA, data: 8'h55};
            C_OPEN:   c = '{addr: 15'h5555, data: 8'hA0};
            C_ERA80:  c = '{addr: 15'h5555, data: 8'h80};
            default:  c = '{addr: 15'h5555, data: 8'h20};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/wpg_cmd_match.sv
module wpg_cmd_match
    import wpg_pkg::*;
(
    input  logic [CMD_AW-1:0]  addr_lo,
    input  logic [CODE_W-1:0]  data,
    output logic [N_CODES-1:0] hit
);

    for (genvar g = 0; g < N_CODES; g++) begin : g_code
        localparam cmd_code_t CODE = code_at(g);
        assign hit[g] = (addr_lo == CODE.addr) && (data == CODE.data);
    end

endmodule

// File: rtl/wpg_seq_fsm.sv
module wpg_seq_fsm
    import wpg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_valid,
    input  logic [N_CODES-1:0] hit,
    input  logic               cycle_done,
    input  logic               prot,
    output logic               wr_kick,
    output logic               wr_commit,
    output logic               set_req,
    output logic               clr_req
);

    seq_state_t state_q, state_d;
    logic       commit_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state and per-write verdict
    always_comb begin
        state_d  = state_q;
        commit_d = 1'b0;
        set_req  = 1'b0;
        clr_req  = 1'b0;
        if (wr_valid) begin
            unique case (state_q)
                S_IDLE: begin
                    if (hit[C_KEY_AA]) state_d = S_KEY1;
                    else               commit_d = !prot;
                end
                S_KEY1: begin
                    if (hit[C_KEY_55]) state_d = S_KEY2;
                    else begin state_d = S_IDLE; commit_d = !prot; end
                end
                S_KEY2: begin
                    if (hit[C_OPEN])       state_d = S_OPEN;
                    else if (hit[C_ERA80]) state_d = S_ERA1;
                    else begin state_d = S_IDLE; commit_d = !prot; end
                end
                S_ERA1: begin
                    if (hit[C_KEY_AA]) state_d = S_ERA2;
                    else begin state_d = S_IDLE; commit_d = !prot; end
                end
                S_ERA2: begin
                    if (hit[C_KEY_55]) state_d = S_ERA3;
                    else begin state_d = S_IDLE; commit_d = !prot; end
                end
                S_ERA3: begin
                    if (hit[C_CLR20]) state_d = S_CLEAR;
                    else begin state_d = S_IDLE; commit_d = !prot; end
                end
                S_OPEN, S_CLEAR: commit_d = 1'b1;
            endcase
        end
        if (cycle_done) begin
            state_d = S_IDLE;
            set_req = rst_n && (state_q == S_OPEN);
            clr_req = rst_n && (state_q == S_CLEAR);
        end
    end

    // registered outputs to the page engine
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_kick   <= 1'b0;
            wr_commit <= 1'b0;
        end else begin
            wr_kick   <= wr_valid;
            wr_commit <= commit_d;
        end
    end

endmodule

// File: rtl/wpg_nv_flag.sv
module wpg_nv_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic prot,
    output logic toggle
);

    logic prot_q = 1'b0;

    always_ff @(posedge clk) begin
        if (set_req)      prot_q <= 1'b1;
        else if (clr_req) prot_q <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) toggle <= 1'b0;
        else        toggle <= (set_req && !prot_q) || (clr_req && !set_req && prot_q);
    end

    assign prot = prot_q;

endmodule

// File: rtl/wp_seq_guard.sv
module wp_seq_guard
    import wpg_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cycle_done,
    output logic              wr_kick,
    output logic              wr_commit,
    output logic              protect_active,
    output logic              protect_toggle
);

    logic [N_CODES-1:0] hit;
    logic               set_req, clr_req;
    logic               addr_hi_unused;

    assign addr_hi_unused = ^wr_addr[ADDR_W-1:CMD_AW];

    wpg_cmd_match u_match (
        .addr_lo (wr_addr[CMD_AW-1:0]),
        .data    (wr_data),
        .hit     (hit)
    );

    wpg_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid   (wr_valid),
        .hit        (hit),
        .cycle_done (cycle_done),
        .prot       (protect_active),
        .wr_kick    (wr_kick),
        .wr_commit  (wr_commit),
        .set_req    (set_req),
        .clr_req    (clr_req)
    );

    wpg_nv_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (set_req),
        .clr_req (clr_req),
        .prot    (protect_active),
        .toggle  (protect_toggle)
    );

endmodule

// File: rtl/wp_seq_guard_chk.sv
module wp_seq_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_valid,
    input logic cycle_done,
    input logic wr_kick,
    input logic wr_commit,
    input logic protect_active,
    input logic protect_toggle
);

    // R2
    kick_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> wr_kick);

    // R2
    no_stray_kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> !wr_kick);

    // R3
    commit_with_kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> wr_kick);

    // R4
    flag_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cycle_done |=> $stable(protect_active));

    // R11
    toggle_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (protect_toggle == (protect_active != $past(protect_active))));

    // R11
    toggle_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        protect_toggle |=> !protect_toggle);

endmodule

bind wp_seq_guard wp_seq_guard_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_valid       (wr_valid),
    .cycle_done     (cycle_done),
    .wr_kick        (wr_kick),
    .wr_commit      (wr_commit),
    .protect_active (protect_active),
    .protect_toggle (protect_toggle)
);

// File: tb/wp_seq_guard_tb.sv
`timescale 1ns/1ps
module wp_seq_guard_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [16:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        cycle_done = 1'b0;
    logic        wr_kick, wr_commit, protect_active, protect_toggle;

    int checks = 0;
    int fails  = 0;
    bit exp_q[$];
    string tag_q[$];
    bit done_flag = 1'b0;

    always #2 clk = ~clk;

    wp_seq_guard u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_valid       (wr_valid),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .cycle_done     (cycle_done),
        .wr_kick        (wr_kick),
        .wr_commit      (wr_commit),
        .protect_active (protect_active),
        .protect_toggle (protect_toggle)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    // driver: one write, pushes the expected commit verdict
    task automatic wr(input logic [16:0] a, input logic [7:0] d, input bit exp, input string tag);
        @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    // monitor: pops one item per kick (R2) and compares the commit verdict
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            if (wr_kick) begin
                if (exp_q.size() == 0) begin
                    chk("R2 stray kick", 1'b1, 1'b0);
                end else begin
                    bit    e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(t, wr_commit, e);
                end
            end else if (wr_commit) begin
                chk("R3 commit without kick", 1'b1, 1'b0);
            end
        end
    end

    task automatic finish_period(input logic exp_prot, input logic exp_tog, input string tag);
        @(negedge clk);
        cycle_done = 1'b1;
        @(negedge clk);
        cycle_done = 1'b0;
        chk({tag, " flag"}, protect_active, exp_prot);
        chk({tag, " toggle"}, protect_toggle, exp_tog);
        @(negedge clk);
        chk("R11 toggle width", protect_toggle, 1'b0);
    endtask

    task automatic key(input string tag);
        wr(17'h05555, 8'hAA, 1'b0, tag);
        wr(17'h02AAA, 8'h55, 1'b0, tag);
        wr(17'h05555, 8'hA0, 1'b0, tag);
    endtask

    task automatic erase(input string tag);
        wr(17'h05555, 8'hAA, 1'b0, tag);
        wr(17'h02AAA, 8'h55, 1'b0, tag);
        wr(17'h05555, 8'h80, 1'b0, tag);
        wr(17'h05555, 8'hAA, 1'b0, tag);
        wr(17'h02AAA, 8'h55, 1'b0, tag);
        wr(17'h05555, 8'h20, 1'b0, tag);
    endtask

    task automatic pulse_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(4.0 * 200000);
        fails++;
        $display("FAIL watchdog: got running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 flag at power-up", protect_active, 1'b0);
        chk("R1 kick under reset", wr_kick, 1'b0);
        chk("R1 commit under reset", wr_commit, 1'b0);
        chk("R1 toggle under reset", protect_toggle, 1'b0);
        rst_n = 1'b1;

        wr(17'h00100, 8'h12, 1'b1, "R3 plain write unprotected");
        wr(17'h05555, 8'hAA, 1'b0, "R8 first key byte");
        wr(17'h03000, 8'h77, 1'b1, "R8 breaking write unprotected");

        wr(17'h1D555, 8'hAA, 1'b0, "R9 high bits ignored");
        wr(17'h12AAA, 8'h55, 1'b0, "R9 high bits ignored");
        wr(17'h00010, 8'h05, 1'b1, "R9 break after masked key");

        wr(17'h05555, 8'hAA, 1'b0, "R1 key before reset");
        wr(17'h02AAA, 8'h55, 1'b0, "R1 key before reset");
        pulse_reset();
        wr(17'h05555, 8'hA0, 1'b1, "R1 reset returns to idle");
        chk("R1 flag after mid reset", protect_active, 1'b0);

        key("R7 arm key");
        finish_period(1'b1, 1'b1, "R7 arm with no data");

        wr(17'h00400, 8'h3C, 1'b0, "R4 protected plain write");
        chk("R4 flag unchanged", protect_active, 1'b1);

        wr(17'h05555, 8'hAA, 1'b0, "R10 partial key");
        wr(17'h02AAA, 8'h55, 1'b0, "R10 partial key");
        finish_period(1'b1, 1'b0, "R10 period ends mid key");
        wr(17'h05555, 8'hA0, 1'b0, "R10 stale third byte");
        wr(17'h00500, 8'h11, 1'b0, "R10 no burst opened");

        key("R5 unlock key");
        wr(17'h00600, 8'hC1, 1'b1, "R5 burst byte 0");
        wr(17'h00601, 8'hC2, 1'b1, "R5 burst byte 1");
        finish_period(1'b1, 1'b0, "R12 unlock while protected");

        pulse_reset();
        chk("R1 reset keeps flag", protect_active, 1'b1);

        wr(17'h05555, 8'hAA, 1'b0, "R8 key byte protected");
        wr(17'h04000, 8'h99, 1'b0, "R8 break while protected");

        erase("R6 erase pattern");
        wr(17'h00700, 8'h5A, 1'b1, "R6 data after erase");
        finish_period(1'b0, 1'b1, "R6 erase clears");

        wr(17'h00800, 8'h01, 1'b1, "R3 write after erase");

        key("R5 arm again");
        wr(17'h00900, 8'h02, 1'b1, "R5 data after arm");
        finish_period(1'b1, 1'b1, "R5 arm sets");
        erase("R7 erase no data");
        finish_period(1'b0, 1'b1, "R7 erase with no data");

        repeat (2) @(negedge clk);
        chk("R2 all kicks seen", exp_q.size() == 0, 1'b1);
        done_flag = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule